// File: doc/BRIEF.md
# Snooping Three-State Cache Line Controller

This block keeps the coherence state of one cache line in a write-back, write-invalidate cache that sits on a shared snooping bus. The line is Invalid, Shared (clean, readable) or Exclusive (sole copy, writable, dirty). A tag register with one comparator stands in for the tag array. The data array, memory and bus arbiter are outside the block.

The processor side presents a read or write with a tag. It holds the request until `cpu_done_o` pulses, and `cpu_hit_o` tells whether that completion was a hit. When a request misses, the block raises `bus_req_o` with a command and a tag. The state and tag change only in a cycle where `bus_gnt_i` answers that request. A write to a Shared line is a full write miss, not an upgrade. A miss that would replace a dirty line first writes the old block back, which leaves the line Invalid. The miss is then placed as a second bus transaction. The snoop side sees other caches' transactions. A snooped miss that hits an Exclusive line raises `snoop_flush_o`, telling the bus to take the dirty data and abort the memory read. A snoop that hits the line takes priority over the processor in that cycle, and the processor request is re-evaluated from the new state.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (line_state_o = 0) with tag 0, and bus_req_o, cpu_done_o, cpu_hit_o and snoop_flush_o are low. bus_cmd_o is 0 and bus_tag_o is 0 whenever bus_req_o is low.
- R2: A read whose tag matches a Shared (1) or Exclusive (2) line, or a write whose tag matches an Exclusive line, raises cpu_done_o and cpu_hit_o in the same cycle with no bus request and no state change.
- R3: A read that misses and needs no write-back requests the bus with command read-miss (1) and the processor tag. On grant, the line becomes Shared with that tag, and cpu_done_o pulses with cpu_hit_o low.
- R4: A write that misses and needs no write-back requests the bus with command write-miss (2) and the processor tag. On grant, the line becomes Exclusive with that tag, and cpu_done_o pulses with cpu_hit_o low. Writes to Shared lines always take this path.
- R5: A read or write to a different tag while the line is Exclusive first requests write-back (3) with the line's old tag. On grant, the line becomes Invalid with its tag kept, and cpu_done_o stays low. The miss of R3 or R4 follows.
- R6: While bus_req_o is high and bus_gnt_i is low, line state and tag do not change.
- R7: A snooped read-miss (1) whose tag matches an Exclusive line raises snoop_flush_o in that cycle, and the line is Shared on the next cycle.
- R8: A snooped write-miss (2) whose tag matches a valid line makes the line Invalid on the next cycle. snoop_flush_o is high in that cycle only if the line was Exclusive.
- R9: In a cycle where snoop_valid_i carries a read-miss or write-miss whose tag matches a valid line, bus_req_o and cpu_done_o stay low. The snoop is applied, and the processor request is re-evaluated in the next cycle.
- R10: A snoop with a non-matching tag, to an Invalid line, with command 0 or 3, or a read-miss to a Shared line, changes nothing and leaves snoop_flush_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_valid_i | input | 1 | Processor request present, held until done |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_tag_i | input | TAG_W | Processor request tag |
| cpu_done_o | output | 1 | Request completes this cycle |
| cpu_hit_o | output | 1 | Completion is a hit |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_gnt_i | input | 1 | Bus granted for the requested transaction |
| bus_cmd_o | output | 2 | 0 none, 1 read-miss, 2 write-miss, 3 write-back |
| bus_tag_o | output | TAG_W | Tag of the requested transaction |
| snoop_valid_i | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snoop_tag_i | input | TAG_W | Snooped tag |
| snoop_flush_o | output | 1 | Supply dirty line and abort the memory access |
| line_state_o | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive |
| line_tag_o | output | TAG_W | Tag held by the line |

## Verification
The assertions assume the bus grant is only meaningful in a cycle where this block is requesting. They also assume the processor holds its request stable until done, and that a snoop and our own granted transaction may share a cycle only because snoop priority is defined for it. The stimulus keeps every request stable until completion, including across cycles where a snoop preempts it. It issues grants both alone and together with snoops, so that the priority rule is exercised and not avoided. Every cycle is compared against a behavioural model that tracks state and tag as integers.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD_MISS = 2'd1,
    CMD_WR_MISS = 2'd2,
    CMD_WBACK = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  line_state_e      state_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             snoop_valid_i,
  input  logic [1:0]       snoop_cmd_i,
  input  logic [TAG_W-1:0] snoop_tag_i,
  output logic             snoop_hit_o,
  output logic             flush_o,
  output line_state_e      nxt_state_o
);
  logic is_miss_cmd;

  assign is_miss_cmd = (snoop_cmd_i == CMD_RD_MISS) || (snoop_cmd_i == CMD_WR_MISS);
  assign snoop_hit_o = snoop_valid_i && is_miss_cmd && (state_i != LINE_I)
                       && (snoop_tag_i == tag_i);
  assign flush_o     = snoop_hit_o && (state_i == LINE_E);

  always_comb begin
    nxt_state_o = state_i;
    if (snoop_hit_o) begin
      if (snoop_cmd_i == CMD_WR_MISS) nxt_state_o = LINE_I;
      else                            nxt_state_o = LINE_S;
    end
  end
endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  line_state_e      state_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             cpu_valid_i,
  input  logic             cpu_write_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  logic             block_i,
  input  logic             bus_gnt_i,
  output logic             cpu_done_o,
  output logic             cpu_hit_o,
  output logic             bus_req_o,
  output bus_cmd_e         bus_cmd_o,
  output logic [TAG_W-1:0] bus_tag_o,
  output logic             upd_o,
  output line_state_e      nxt_state_o,
  output logic [TAG_W-1:0] nxt_tag_o
);
  logic tag_eq, hit, need_wb, active;

  assign tag_eq  = (cpu_tag_i == tag_i);
  assign hit     = tag_eq && ((state_i == LINE_E) || (state_i == LINE_S && !cpu_write_i));
  assign need_wb = (state_i == LINE_E) && !tag_eq;
  assign active  = cpu_valid_i && !block_i;

  always_comb begin
    cpu_done_o  = 1'b0;
    cpu_hit_o   = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_tag_o   = '0;
    upd_o       = 1'b0;
    nxt_state_o = state_i;
    nxt_tag_o   = tag_i;
    if (active) begin
      if (hit) begin
        cpu_done_o = 1'b1;
        cpu_hit_o  = 1'b1;
      end else if (need_wb) begin
        bus_req_o = 1'b1;
        bus_cmd_o = CMD_WBACK;
        bus_tag_o = tag_i;
        if (bus_gnt_i) begin
          upd_o       = 1'b1;
          nxt_state_o = LINE_I;
        end
      end else begin
        bus_req_o = 1'b1;
        bus_cmd_o = cpu_write_i ? CMD_WR_MISS : CMD_RD_MISS;
        bus_tag_o = cpu_tag_i;
        if (bus_gnt_i) begin
          upd_o       = 1'b1;
          cpu_done_o  = 1'b1;
          nxt_state_o = cpu_write_i ? LINE_E : LINE_S;
          nxt_tag_o   = cpu_tag_i;
        end
      end
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_valid_i,
  input  logic             cpu_write_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  output logic             cpu_done_o,
  output logic             cpu_hit_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic [1:0]       bus_cmd_o,
  output logic [TAG_W-1:0] bus_tag_o,
  input  logic             snoop_valid_i,
  input  logic [1:0]       snoop_cmd_i,
  input  logic [TAG_W-1:0] snoop_tag_i,
  output logic             snoop_flush_o,
  output logic [1:0]       line_state_o,
  output logic [TAG_W-1:0] line_tag_o
);
  line_state_e      state_q, snp_nxt, req_nxt;
  logic [TAG_W-1:0] tag_q, req_tag;
  logic             snp_hit, req_upd;
  bus_cmd_e         cmd;

  msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .state_i      (state_q),
    .tag_i        (tag_q),
    .snoop_valid_i(snoop_valid_i),
    .snoop_cmd_i  (snoop_cmd_i),
    .snoop_tag_i  (snoop_tag_i),
    .snoop_hit_o  (snp_hit),
    .flush_o      (snoop_flush_o),
    .nxt_state_o  (snp_nxt)
  );

  msi_req_unit #(.TAG_W(TAG_W)) u_req (
    .state_i    (state_q),
    .tag_i      (tag_q),
    .cpu_valid_i(cpu_valid_i),
    .cpu_write_i(cpu_write_i),
    .cpu_tag_i  (cpu_tag_i),
    .block_i    (snp_hit),
    .bus_gnt_i  (bus_gnt_i),
    .cpu_done_o (cpu_done_o),
    .cpu_hit_o  (cpu_hit_o),
    .bus_req_o  (bus_req_o),
    .bus_cmd_o  (cmd),
    .bus_tag_o  (bus_tag_o),
    .upd_o      (req_upd),
    .nxt_state_o(req_nxt),
    .nxt_tag_o  (req_tag)
  );

  // snoop wins; request unit is blocked in that cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINE_I;
      tag_q   <= '0;
    end else if (snp_hit) begin
      state_q <= snp_nxt;
    end else if (req_upd) begin
      state_q <= req_nxt;
      tag_q   <= req_tag;
    end
  end

  assign bus_cmd_o    = cmd;
  assign line_state_o = state_q;
  assign line_tag_o   = tag_q;
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int TAG_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_valid_i,
  input logic             cpu_write_i,
  input logic [TAG_W-1:0] cpu_tag_i,
  input logic             cpu_done_o,
  input logic             cpu_hit_o,
  input logic             bus_req_o,
  input logic             bus_gnt_i,
  input logic [1:0]       bus_cmd_o,
  input logic [TAG_W-1:0] bus_tag_o,
  input logic             snoop_valid_i,
  input logic [1:0]       snoop_cmd_i,
  input logic [TAG_W-1:0] snoop_tag_i,
  input logic             snoop_flush_o,
  input logic [1:0]       line_state_o,
  input logic [TAG_W-1:0] line_tag_o
);
  logic snp_match;
  assign snp_match = snoop_valid_i && (snoop_cmd_i == 2'd1 || snoop_cmd_i == 2'd2)
                     && line_state_o != 2'd0 && snoop_tag_i == line_tag_o;

  // R1
  idle_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (bus_cmd_o == 2'd0 && bus_tag_o == '0));

  // R2
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (cpu_done_o && !bus_req_o && cpu_valid_i));

  // R2
  hit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |=> ($stable(line_state_o) && $stable(line_tag_o)));

  // R3
  rd_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == 2'd1) |=> (line_state_o == 2'd1 && line_tag_o == $past(cpu_tag_i)));

  // R4
  wr_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == 2'd2 && cpu_write_i) |=> line_state_o == 2'd2);

  // R5
  wb_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'd3) |-> (line_state_o == 2'd2 && bus_tag_o == line_tag_o && !cpu_done_o));

  // R6
  wait_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> ($stable(line_state_o) && $stable(line_tag_o)));

  // R7
  flush_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_flush_o |-> (line_state_o == 2'd2 && snp_match));

  // R7
  snoop_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_match && snoop_cmd_i == 2'd1) |=> line_state_o == 2'd1);

  // R8
  snoop_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_match && snoop_cmd_i == 2'd2) |=> line_state_o == 2'd0);

  // R9
  snoop_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_match |-> (!bus_req_o && !cpu_done_o));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_valid_i  (cpu_valid_i),
  .cpu_write_i  (cpu_write_i),
  .cpu_tag_i    (cpu_tag_i),
  .cpu_done_o   (cpu_done_o),
  .cpu_hit_o    (cpu_hit_o),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_cmd_o    (bus_cmd_o),
  .bus_tag_o    (bus_tag_o),
  .snoop_valid_i(snoop_valid_i),
  .snoop_cmd_i  (snoop_cmd_i),
  .snoop_tag_i  (snoop_tag_i),
  .snoop_flush_o(snoop_flush_o),
  .line_state_o (line_state_o),
  .line_tag_o   (line_tag_o)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
  localparam int TAG_W = 20;
  localparam int CLK_PERIOD = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cpu_valid_i = 1'b0, cpu_write_i = 1'b0, bus_gnt_i = 1'b0, snoop_valid_i = 1'b0;
  logic [TAG_W-1:0] cpu_tag_i = '0, snoop_tag_i = '0;
  logic [1:0]       snoop_cmd_i = 2'd0;
  logic             cpu_done_o, cpu_hit_o, bus_req_o, snoop_flush_o;
  logic [1:0]       bus_cmd_o, line_state_o;
  logic [TAG_W-1:0] bus_tag_o, line_tag_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural model of the line
  int m_state = 0;
  int m_tag = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  msi_line_ctrl #(.TAG_W(TAG_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid_i), .cpu_write_i(cpu_write_i), .cpu_tag_i(cpu_tag_i),
    .cpu_done_o(cpu_done_o), .cpu_hit_o(cpu_hit_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_cmd_o(bus_cmd_o), .bus_tag_o(bus_tag_o),
    .snoop_valid_i(snoop_valid_i), .snoop_cmd_i(snoop_cmd_i), .snoop_tag_i(snoop_tag_i),
    .snoop_flush_o(snoop_flush_o), .line_state_o(line_state_o), .line_tag_o(line_tag_o)
  );

  task automatic cmp(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model, wait for next negedge
  task automatic cyc(input bit cv, input bit cw, input int ct, input bit g,
                     input bit sv, input int sc, input int st, input string req);
    int e_done, e_hit, e_req, e_cmd, e_btag, e_flush, n_state, n_tag;
    bit snp;
    cpu_valid_i = cv; cpu_write_i = cw; cpu_tag_i = ct[TAG_W-1:0]; bus_gnt_i = g;
    snoop_valid_i = sv; snoop_cmd_i = sc[1:0]; snoop_tag_i = st[TAG_W-1:0];
    #1;
    e_done = 0; e_hit = 0; e_req = 0; e_cmd = 0; e_btag = 0; e_flush = 0;
    n_state = m_state; n_tag = m_tag;
    snp = sv && (sc == 1 || sc == 2) && m_state != 0 && st == m_tag;
    if (snp) begin
      if (m_state == 2) e_flush = 1;
      n_state = (sc == 2) ? 0 : 1;
    end else if (cv) begin
      if (ct == m_tag && (m_state == 2 || (m_state == 1 && !cw))) begin
        e_done = 1; e_hit = 1;
      end else if (m_state == 2) begin
        e_req = 1; e_cmd = 3; e_btag = m_tag;
        if (g) n_state = 0;
      end else begin
        e_req = 1; e_cmd = cw ? 2 : 1; e_btag = ct;
        if (g) begin
          e_done = 1; n_state = cw ? 2 : 1; n_tag = ct;
        end
      end
    end
    cmp(req, "line_state", int'(line_state_o), m_state);
    cmp(req, "line_tag", int'(line_tag_o), m_tag);
    cmp(req, "cpu_done", int'(cpu_done_o), e_done);
    cmp(req, "cpu_hit", int'(cpu_hit_o), e_hit);
    cmp(req, "bus_req", int'(bus_req_o), e_req);
    cmp(req, "bus_cmd", int'(bus_cmd_o), e_cmd);
    cmp(req, "bus_tag", int'(bus_tag_o), e_btag);
    cmp(req, "snoop_flush", int'(snoop_flush_o), e_flush);
    m_state = n_state; m_tag = n_tag;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    cyc(0,0,0,0, 0,0,0, "R1");
    cyc(0,0,0,1, 1,2,0, "R1_R10");

    // R6 wait for grant, R3 read miss from Invalid
    cyc(1,0,'h1A,0, 0,0,0, "R6");
    cyc(1,0,'h1A,0, 0,0,0, "R6");
    cyc(1,0,'h1A,1, 0,0,0, "R3");
    // R2 read hit in Shared
    cyc(1,0,'h1A,0, 0,0,0, "R2");
    // R4 write to Shared is a write miss
    cyc(1,1,'h1A,0, 0,0,0, "R4");
    cyc(1,1,'h1A,1, 0,0,0, "R4");
    // R2 hits in Exclusive
    cyc(1,0,'h1A,0, 0,0,0, "R2");
    cyc(1,1,'h1A,0, 0,0,0, "R2");
    cyc(0,0,0,0, 0,0,0, "R2");

    // R10 non-matching / ignored snoops
    cyc(0,0,0,0, 1,1,'h2B, "R10");
    cyc(0,0,0,0, 1,3,'h1A, "R10");
    cyc(0,0,0,0, 1,0,'h1A, "R10");
    // R7 snooped read miss on Exclusive
    cyc(0,0,0,0, 1,1,'h1A, "R7");
    cyc(0,0,0,0, 0,0,0, "R7");
    // R10 read miss on Shared, R8 write miss on Shared
    cyc(0,0,0,0, 1,1,'h1A, "R10");
    cyc(0,0,0,0, 1,2,'h1A, "R8");
    cyc(0,0,0,0, 1,2,'h1A, "R10");

    // R4 write from Invalid, then R8 snooped write miss on Exclusive
    cyc(1,1,'h1A,1, 0,0,0, "R4");
    cyc(0,0,0,0, 1,2,'h1A, "R8");
    cyc(0,0,0,0, 0,0,0, "R8");

    // R5 replacement of dirty line before read miss
    cyc(1,1,'h1A,1, 0,0,0, "R4");
    cyc(1,0,'h2B,0, 0,0,0, "R5");
    cyc(1,0,'h2B,1, 0,0,0, "R5");
    cyc(1,0,'h2B,0, 0,0,0, "R3");
    cyc(1,0,'h2B,1, 0,0,0, "R3");
    // R4 write to other tag from Shared, no write-back
    cyc(1,1,'h3C,1, 0,0,0, "R4");
    // R5 replacement before write miss
    cyc(1,1,'h4D,1, 0,0,0, "R5");
    cyc(1,1,'h4D,1, 0,0,0, "R5");
    cyc(0,0,0,0, 0,0,0, "R5");

    // R9 snoop preempts a pending write-back even with grant
    cyc(1,0,'h5E,1, 1,2,'h4D, "R9");
    cyc(1,0,'h5E,1, 0,0,0, "R9");
    // R9 snoop preempts a hit in Shared
    cyc(1,0,'h5E,0, 1,1,'h5E, "R9");
    cyc(1,0,'h5E,0, 0,0,0, "R9");
    // R9 snoop on Shared preempts a write miss
    cyc(1,1,'h5E,1, 1,2,'h5E, "R9");
    cyc(1,1,'h5E,1, 0,0,0, "R9");
    // R6 pending write-back waits
    cyc(1,0,'h6F,0, 0,0,0, "R6");
    cyc(1,0,'h6F,0, 1,1,'h6F, "R6_R10");
    cyc(1,0,'h6F,1, 0,0,0, "R5");
    cyc(1,0,'h6F,1, 0,0,0, "R3");
    cyc(0,0,0,0, 0,0,0, "R1");

    finish_run();
  end
endmodule